// File: doc/BRIEF.md
# Over-charge protection controller

This block is the digital control logic that protects a series pack of three or four lithium cells against over-charge. Analog comparators outside the block report, for each cell, whether it sits above the over-charge trip level and whether it sits below the lower release level. The block qualifies a trip over a programmable number of slow-tick periods, raises a charge-inhibit output, and turns on a bleed switch for each offending cell. Each bleed switch drops on its own once its cell reaches the release level. Charge is allowed again after every tripped cell has stayed below the release level for a second programmable delay.

The block also has an early exit. If the pack starts to discharge while charge is inhibited (a flag from a supply-to-pack-terminal comparator), charge is re-enabled at once and every bleed switch opens. A later rise above the trip level must then qualify from the start. Three further inputs act on the outputs: a per-cell short-cell flag forces charge inhibit unless the supply-low flag is set, a cell-count mode masks the top cell's short flag, and a remote-off input forces both charge and discharge inhibit while the detection logic keeps running underneath.

Both delays are counted in ticks of a slow enable. Each is a parameter.

Top module: `ovc_guard`

## Requirements
- R1: After reset, chg_inhibit, dsg_inhibit and every bit of bleed_en are 0.
- R2: When at least one above_trip bit stays 1 across QUAL_TICKS consecutive tick pulses, chg_inhibit is 1 from the clock edge that samples the last of those ticks.
- R3: If every above_trip bit returns to 0 before the qualification delay completes, chg_inhibit stays 0, and the next excursion counts from zero.
- R4: Once tripped, chg_inhibit returns to 0 after every tripped cell has had its below_rel bit at 1 across REL_TICKS consecutive tick pulses.
- R5: If any tripped cell's below_rel bit returns to 0 during the release count, the count starts again from zero.
- R6: On entry to the tripped state, bleed_en[i] is set exactly for the cells whose above_trip bit is 1. Each set bit clears on its own once that cell's below_rel bit is 1, and no bit of bleed_en rises at any other time.
- R7: While tripped, dischg_seen = 1 clears chg_inhibit (unless forced by R9 or R11) and every bleed_en bit at the next clock edge, even when cells are still above the release level.
- R8: After an early release under R7, a cell that is still above the trip level must qualify again for the full QUAL_TICKS before charge is inhibited.
- R9: Any enabled short_cell bit forces chg_inhibit to 1 at the next edge while supply_low is 0. With supply_low = 1 the short flags have no effect.
- R10: With full_mode = 0 (three-cell mode), short_cell[NCELL-1] is ignored. With full_mode = 1 all short_cell bits are enabled.
- R11: While remote_off is 1, chg_inhibit and dsg_inhibit are 1 from the next edge. Trip qualification and the bleed switches keep operating, so a trip qualified under remote-off remains in force after remote_off returns to 0.
- R12: dischg_seen has no effect when the block is not in the tripped state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow time-base enable, one cycle wide |
| above_trip | input | NCELL | Per-cell flag: cell above over-charge trip level |
| below_rel | input | NCELL | Per-cell flag: cell below release level |
| short_cell | input | NCELL | Per-cell flag: cell voltage near zero |
| full_mode | input | 1 | 1 = four-cell mode, 0 = three-cell mode |
| supply_low | input | 1 | Supply too low for short-cell detection to be trusted |
| dischg_seen | input | 1 | Pack discharge detected |
| remote_off | input | 1 | Remote request to force both FETs off |
| chg_inhibit | output | 1 | Charge inhibit |
| dsg_inhibit | output | 1 | Discharge inhibit |
| bleed_en | output | NCELL | Per-cell bleed switch enable |

## Verification
The trip path is driven with an excursion that ends before qualification (separates R3 from R2), two cells tripping together and releasing one at a time (separates per-cell bleed drop from the common release), and a release interrupted by a cell rising again (shows that the release counter restarts). A trip cut short by discharge, with the cell still held high, separates an early release from a normal one and shows that requalification starts from zero. The short-cell, supply-low and mode inputs are toggled in combination to show which flags are masked. A trip is also qualified underneath remote-off to show that detection continues while the outputs are forced.

// File: rtl/ovc_pkg.sv
package ovc_pkg;

    typedef enum logic {
        ST_WATCH   = 1'b0,
        ST_TRIPPED = 1'b1
    } ovc_state_e;

endpackage

// File: rtl/ovc_tick_timer.sv
module ovc_tick_timer #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);

    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done_o = run_i && tick_i && (cnt_q == LAST);
        cnt_d  = cnt_q;
        if (!run_i || done_o) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: count never passes the programmed limit
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R3/R5: an interrupted run restarts from zero
    assert_restart_from_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/ovc_bleed_bank.sv
module ovc_bleed_bank #(
    parameter int unsigned NCELL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [NCELL-1:0] load_mask_i,
    input  logic             drop_all_i,
    input  logic [NCELL-1:0] below_rel_i,
    output logic [NCELL-1:0] bleed_o
);

    logic [NCELL-1:0] bleed_d, bleed_q;

    for (genvar g = 0; g < NCELL; g++) begin : g_cell
        always_comb begin
            bleed_d[g] = bleed_q[g] & ~below_rel_i[g];
            if (drop_all_i) begin
                bleed_d[g] = 1'b0;
            end else if (load_i) begin
                bleed_d[g] = load_mask_i[g];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bleed_q[g] <= 1'b0;
            else        bleed_q[g] <= bleed_d[g];
        end

        // R6: a switch turns on only at trip entry
        assert_bleed_no_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !load_i |=> !$rose(bleed_q[g]));

        // R6: a switch whose cell reached release opens
        assert_bleed_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!load_i && below_rel_i[g]) |=> !bleed_q[g]);
    end

    assign bleed_o = bleed_q;

endmodule

// File: rtl/ovc_guard.sv
module ovc_guard
    import ovc_pkg::*;
#(
    parameter int unsigned NCELL      = 4,
    parameter int unsigned QUAL_TICKS = 23,
    parameter int unsigned REL_TICKS  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [NCELL-1:0] above_trip,
    input  logic [NCELL-1:0] below_rel,
    input  logic [NCELL-1:0] short_cell,
    input  logic             full_mode,
    input  logic             supply_low,
    input  logic             dischg_seen,
    input  logic             remote_off,
    output logic             chg_inhibit,
    output logic             dsg_inhibit,
    output logic [NCELL-1:0] bleed_en
);

    localparam logic [NCELL-1:0] ALL_CELLS   = '1;
    localparam logic [NCELL-1:0] LOWER_CELLS = {1'b0, {(NCELL-1){1'b1}}};

    typedef struct packed {
        ovc_state_e       st;
        logic [NCELL-1:0] mask;
        logic             chg;
        logic             dsg;
    } guard_t;

    guard_t g_d, g_q;

    logic any_above, all_rel, qual_run, rel_run, qual_done, rel_done;
    logic fast_exit, short_force;
    logic [NCELL-1:0] short_en;

    always_comb begin
        any_above   = |above_trip;
        all_rel     = &(below_rel | ~g_q.mask);
        qual_run    = (g_q.st == ST_WATCH) && any_above;
        rel_run     = (g_q.st == ST_TRIPPED) && all_rel && !dischg_seen;
        fast_exit   = (g_q.st == ST_TRIPPED) && dischg_seen;
        short_en    = full_mode ? ALL_CELLS : LOWER_CELLS;
        short_force = (|(short_cell & short_en)) && !supply_low;
    end

    ovc_tick_timer #(.LIMIT(QUAL_TICKS)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (qual_run),
        .tick_i (tick),
        .done_o (qual_done)
    );

    ovc_tick_timer #(.LIMIT(REL_TICKS)) u_rel (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (rel_run),
        .tick_i (tick),
        .done_o (rel_done)
    );

    always_comb begin
        g_d = g_q;
        if (qual_done) begin
            g_d.st   = ST_TRIPPED;
            g_d.mask = above_trip;
        end else if (fast_exit || rel_done) begin
            g_d.st   = ST_WATCH;
            g_d.mask = '0;
        end
        g_d.chg = (g_d.st == ST_TRIPPED) || short_force || remote_off;
        g_d.dsg = remote_off;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.st   <= ST_WATCH;
            g_q.mask <= '0;
            g_q.chg  <= 1'b0;
            g_q.dsg  <= 1'b0;
        end else begin
            g_q <= g_d;
        end
    end

    ovc_bleed_bank #(.NCELL(NCELL)) u_bleed (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (qual_done),
        .load_mask_i (above_trip),
        .drop_all_i  (fast_exit),
        .below_rel_i (below_rel),
        .bleed_o     (bleed_en)
    );

    assign chg_inhibit = g_q.chg;
    assign dsg_inhibit = g_q.dsg;

    // R3: the tripped state is entered only while some cell is above trip
    assert_entry_needs_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_q.st) |-> $past(any_above));

    // R7: discharge while tripped releases at once
    assert_fast_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((g_q.st == ST_TRIPPED) && dischg_seen) |=> ((g_q.st == ST_WATCH) && (bleed_en == '0)));

    // R9: an enabled short flag inhibits charge
    assert_short_inhibits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(short_cell & short_en)) && !supply_low) |=> chg_inhibit);

    // R11: remote-off forces both inhibits
    assert_remote_forces_R11: assert property (@(posedge clk) disable iff (!rst_n)
        remote_off |=> (chg_inhibit && dsg_inhibit));

    // R2: tripped state always shows on the charge output
    assert_tripped_inhibits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.st == ST_TRIPPED) |-> chg_inhibit);

endmodule

// File: tb/ovc_guard_tb_top.sv
module ovc_guard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NC   = 4;
    localparam int QUAL = 4;
    localparam int REL  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [NC-1:0] above_trip = '0;
    logic [NC-1:0] below_rel = '1;
    logic [NC-1:0] short_cell = '0;
    logic full_mode = 1'b1;
    logic supply_low = 1'b0;
    logic dischg_seen = 1'b0;
    logic remote_off = 1'b0;
    logic chg_inhibit, dsg_inhibit;
    logic [NC-1:0] bleed_en;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    ovc_guard #(.NCELL(NC), .QUAL_TICKS(QUAL), .REL_TICKS(REL)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .above_trip(above_trip), .below_rel(below_rel), .short_cell(short_cell),
        .full_mode(full_mode), .supply_low(supply_low), .dischg_seen(dischg_seen),
        .remote_off(remote_off), .chg_inhibit(chg_inhibit), .dsg_inhibit(dsg_inhibit),
        .bleed_en(bleed_en)
    );

    // tick every third cycle
    int tphase = 0;
    always @(negedge clk) begin
        tphase = (tphase + 1) % 3;
        tick <= (tphase == 0);
    end

    // behavioural reference model
    bit m_trip = 0;
    int m_qc = 0, m_rc = 0;
    bit [NC-1:0] m_mask = '0, m_bleed = '0;
    bit m_chg = 0, m_dsg = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_trip = 0; m_qc = 0; m_rc = 0; m_mask = '0; m_bleed = '0; m_chg = 0; m_dsg = 0;
        end else begin
            bit [NC-1:0] en;
            if (m_trip) begin
                m_bleed = m_bleed & ~below_rel;
                if (dischg_seen) begin
                    m_trip = 0; m_bleed = '0; m_rc = 0; m_mask = '0;
                end else if ((below_rel | ~m_mask) == '1) begin
                    if (tick) begin
                        m_rc++;
                        if (m_rc == REL) begin m_trip = 0; m_rc = 0; m_mask = '0; end
                    end
                end else m_rc = 0;
            end else begin
                m_bleed = m_bleed & ~below_rel;
                if (above_trip != 0) begin
                    if (tick) begin
                        m_qc++;
                        if (m_qc == QUAL) begin
                            m_trip = 1; m_qc = 0; m_mask = above_trip; m_bleed = above_trip;
                        end
                    end
                end else m_qc = 0;
            end
            en = full_mode ? '1 : 4'b0111;
            m_chg = m_trip || (((short_cell & en) != 0) && !supply_low) || remote_off;
            m_dsg = remote_off;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk({31'd0, chg_inhibit}, {31'd0, m_chg}, {cur_req, " chg_inhibit"});
            chk({31'd0, dsg_inhibit}, {31'd0, m_dsg}, {cur_req, " dsg_inhibit"});
            chk({28'd0, bleed_en}, {28'd0, m_bleed}, {cur_req, " bleed_en"});
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        waitn(3);
        rst_n = 1'b1;
        waitn(1);
        chk({31'd0, chg_inhibit}, 0, "R1 reset chg");
        chk({31'd0, dsg_inhibit}, 0, "R1 reset dsg");
        chk({28'd0, bleed_en}, 0, "R1 reset bleed");

        // R3: short excursion does not trip
        cur_req = "R3";
        above_trip = 4'b0010; below_rel = 4'b1101;
        waitn(6);
        above_trip = 4'b0000; below_rel = 4'b1111;
        waitn(30);
        chk({31'd0, chg_inhibit}, 0, "R3 no trip");

        // R2 / R6: two cells trip
        cur_req = "R2";
        above_trip = 4'b0101; below_rel = 4'b1010;
        waitn(6);
        chk({31'd0, chg_inhibit}, 0, "R2 before delay");
        waitn(12);
        chk({31'd0, chg_inhibit}, 1, "R2 tripped");
        chk({28'd0, bleed_en}, 4'b0101, "R6 bleed loaded");
        cur_req = "R6";
        above_trip = 4'b0000; below_rel = 4'b1011;
        waitn(2);
        chk({28'd0, bleed_en}, 4'b0100, "R6 cell0 drops alone");
        chk({31'd0, chg_inhibit}, 1, "R6 still inhibited");
        below_rel = 4'b1111;
        waitn(12);
        cur_req = "R5";
        below_rel = 4'b1011;
        waitn(1);
        below_rel = 4'b1111;
        waitn(12);
        chk({31'd0, chg_inhibit}, 1, "R5 release restarted");
        cur_req = "R4";
        waitn(15);
        chk({31'd0, chg_inhibit}, 0, "R4 released");

        // R7 / R8: early release by discharge
        cur_req = "R7";
        above_trip = 4'b1000; below_rel = 4'b0111;
        waitn(18);
        chk({31'd0, chg_inhibit}, 1, "R7 tripped first");
        dischg_seen = 1'b1;
        waitn(1);
        dischg_seen = 1'b0;
        waitn(1);
        chk({31'd0, chg_inhibit}, 0, "R7 early release");
        chk({28'd0, bleed_en}, 0, "R7 bleed off");
        cur_req = "R8";
        waitn(6);
        chk({31'd0, chg_inhibit}, 0, "R8 requalifying");
        waitn(12);
        chk({31'd0, chg_inhibit}, 1, "R8 tripped again");
        above_trip = 4'b0000; below_rel = 4'b1111;
        waitn(24);
        chk({31'd0, chg_inhibit}, 0, "R4 released again");

        // R12
        cur_req = "R12";
        dischg_seen = 1'b1;
        waitn(4);
        chk({31'd0, chg_inhibit}, 0, "R12 no effect");
        chk({28'd0, bleed_en}, 0, "R12 bleed");
        dischg_seen = 1'b0;

        // R9
        cur_req = "R9";
        short_cell = 4'b0001;
        waitn(2);
        chk({31'd0, chg_inhibit}, 1, "R9 short forces");
        supply_low = 1'b1;
        waitn(2);
        chk({31'd0, chg_inhibit}, 0, "R9 masked by supply low");
        supply_low = 1'b0; short_cell = 4'b0000;
        waitn(2);

        // R10
        cur_req = "R10";
        full_mode = 1'b0; short_cell = 4'b1000;
        waitn(2);
        chk({31'd0, chg_inhibit}, 0, "R10 top cell ignored");
        full_mode = 1'b1;
        waitn(2);
        chk({31'd0, chg_inhibit}, 1, "R10 top cell used");
        short_cell = 4'b0000;
        waitn(2);

        // R11
        cur_req = "R11";
        remote_off = 1'b1;
        waitn(2);
        chk({31'd0, chg_inhibit}, 1, "R11 chg forced");
        chk({31'd0, dsg_inhibit}, 1, "R11 dsg forced");
        above_trip = 4'b0001; below_rel = 4'b1110;
        waitn(18);
        chk({28'd0, bleed_en}, 4'b0001, "R11 bleed under remote");
        remote_off = 1'b0;
        waitn(2);
        chk({31'd0, chg_inhibit}, 1, "R11 trip kept");
        chk({31'd0, dsg_inhibit}, 0, "R11 dsg freed");
        above_trip = 4'b0000; below_rel = 4'b1111;
        waitn(24);
        chk({31'd0, chg_inhibit}, 0, "R11 released");

        summary();
        $finish;
    end

endmodule